// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one output-compare channel that sits beside a timer counter. The counter value, a run indication and an update-event pulse come in from outside. Each clock, the channel checks the running counter against its active compare value. A hit sets a sticky compare flag and may raise an interrupt level and a one-cycle DMA request. It also moves a registered reference level according to a 3-bit mode field: hold, drive high, drive low or invert on a hit, or force low or high with no comparison at all. The pin level is the reference, optionally inverted, gated by an output enable.

Software programs the channel through a small synchronous write port and a combinational read port. A preload-enable control bit chooses how compare writes land. With the bit clear, a write goes straight into the active compare register. With the bit set, the write is parked in a preload register and the update-event pulse copies it into the active register.

Top module: `cmp_out_chan`

## Requirements
- R1: After reset the reference level, compare flag, control register, active and preload compare values, ch_out, irq and dma_req are all 0.
- R2: A hit is a clock edge at which cnt_run is 1 and cnt_val equals the active compare value. The hit sets the compare flag at that edge. While cnt_run is 0, the flag is never set.
- R3: irq is 1 exactly while the compare flag and the interrupt enable (control bit 6) are both 1. dma_req is 1 for the single cycle after a hit that occurred with the DMA enable (control bit 7) set.
- R4: On a hit, mode 001 sets the reference to 1, mode 010 sets it to 0, and mode 011 inverts it. The mode is control bits [2:0].
- R5: Modes 000, 110 and 111 hold the reference unchanged, hits included.
- R6: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at every edge, whatever the comparison gives.
- R7: ch_out equals reference XOR polarity (control bit 3) while the output enable (control bit 4) is 1, and is 0 while that enable is 0.
- R8: With preload enable (control bit 5) at 0, a write to address 1 loads the active compare value at that edge and also loads the preload register.
- R9: With preload enable at 1, a write to address 1 loads only the preload register. Each update-event pulse that has no such direct write in the same cycle copies the preload register into the active compare value.
- R10: Writing a value with bit 0 set to address 2 clears the flag. A hit at the same edge wins, and the flag stays set.
- R11: Register map: address 0 holds the control byte (writable), address 1 reads the active compare value, address 2 reads the flag in bit 0, and address 3 reads the preload register. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW | Timer counter value |
| cnt_run | input | 1 | Counter is running; hits only while 1 |
| upd_evt | input | 1 | Update-event pulse from the timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CW | Register read data (combinational) |
| ref_lvl | output | 1 | Reference level before polarity and enable |
| ch_out | output | 1 | Channel output pin level |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
Each clocked result appears in the cycle after the edge that samples its cause. That holds for the flag, the reference, the register contents and dma_req: all are due one edge after a hit, a write or an update pulse. ch_out, irq and rd_data follow that state combinationally in the same cycle. The bench drives inputs just after a falling edge and advances its behavioural model at the rising edge with the same inputs. It compares every output and the selected read data at the next falling edge, so each check falls exactly one edge after its stimulus.

// File: rtl/cmp_out_chan.sv
module cmp_out_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_run,
  input  logic          upd_evt,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          ref_lvl,
  output logic          ch_out,
  output logic          irq,
  output logic          dma_req
);
  localparam int CTLW = 8;

  logic [CTLW-1:0] ctl_q;
  logic [CW-1:0]   act_cmp, pre_cmp;
  logic            flag;
  logic [2:0]      mode;
  logic            pol, oe, pe, ie, de;
  logic            hit, ctl_wr, cmp_wr, clr_wr;

  assign mode = ctl_q[2:0];
  assign pol  = ctl_q[3];
  assign oe   = ctl_q[4];
  assign pe   = ctl_q[5];
  assign ie   = ctl_q[6];
  assign de   = ctl_q[7];

  assign hit    = cnt_run && (cnt_val == act_cmp);
  assign ctl_wr = wr_en && (wr_addr == 2'd0);
  assign cmp_wr = wr_en && (wr_addr == 2'd1);
  assign clr_wr = wr_en && (wr_addr == 2'd2) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wr_data[CTLW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cmp <= '0;
      act_cmp <= '0;
    end else begin
      if (cmp_wr) pre_cmp <= wr_data;
      if (cmp_wr && !pe) act_cmp <= wr_data;
      else if (upd_evt) act_cmp <= pre_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_lvl <= 1'b0;
    else begin
      unique case (mode)
        3'b001:  if (hit) ref_lvl <= 1'b1;
        3'b010:  if (hit) ref_lvl <= 1'b0;
        3'b011:  if (hit) ref_lvl <= ~ref_lvl;
        3'b100:  ref_lvl <= 1'b0;
        3'b101:  ref_lvl <= 1'b1;
        default: ref_lvl <= ref_lvl;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (hit) flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
      dma_req <= hit && de;
    end
  end

  assign ch_out = oe && (ref_lvl ^ pol);
  assign irq    = flag && ie;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      2'd0: rd_data[CTLW-1:0] = ctl_q;
      2'd1: rd_data = act_cmp;
      2'd2: rd_data[0] = flag;
      default: rd_data = pre_cmp;
    endcase
  end
endmodule

module cmp_out_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_val,
  input logic          cnt_run,
  input logic [CW-1:0] act_cmp,
  input logic [2:0]    mode,
  input logic          ref_lvl,
  input logic          flag,
  input logic          de,
  input logic          pe,
  input logic          dma_req,
  input logic          cmp_wr,
  input logic          upd_evt
);
  logic m;
  assign m = cnt_run && (cnt_val == act_cmp);

  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) m |=> flag); // R2
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> $past(m && de)); // R3
  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'b001 && m) |=> ref_lvl); // R4
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'b011 && m) |=> ref_lvl != $past(ref_lvl)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'b000 || mode[2:1] == 2'b11) |=> $stable(ref_lvl)); // R5
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n) mode == 3'b100 |=> !ref_lvl); // R6
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) mode == 3'b101 |=> ref_lvl); // R6
  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!(cmp_wr && !pe) && !upd_evt) |=> $stable(act_cmp)); // R9
endmodule

bind cmp_out_chan cmp_out_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_run(cnt_run),
  .act_cmp(act_cmp), .mode(mode), .ref_lvl(ref_lvl), .flag(flag),
  .de(de), .pe(pe), .dma_req(dma_req), .cmp_wr(cmp_wr), .upd_evt(upd_evt)
);

// File: tb/test_cmp_out_chan.sv
`timescale 1ns/1ps
module test_cmp_out_chan;
  localparam int CW = 16;
  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_val = '0, wr_data = '0, rd_data;
  logic cnt_run = 0, upd_evt = 0, wr_en = 0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic ref_lvl, ch_out, irq, dma_req;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_ctl = 0, m_act = 0, m_pre = 0;
  bit m_ref = 0, m_flag = 0, m_dma = 0;

  always #2.5 clk = ~clk;

  cmp_out_chan #(.CW(CW)) i_cmp_out_chan (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_run(cnt_run), .upd_evt(upd_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ref_lvl(ref_lvl), .ch_out(ch_out), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit hit;
    int mode;
    hit = cnt_run && (int'(cnt_val) == m_act);
    mode = m_ctl & 7;
    if (mode == 1 && hit) m_ref = 1;
    else if (mode == 2 && hit) m_ref = 0;
    else if (mode == 3 && hit) m_ref = !m_ref;
    else if (mode == 4) m_ref = 0;
    else if (mode == 5) m_ref = 1;
    if (hit) m_flag = 1;
    else if (wr_en && wr_addr == 2 && wr_data[0]) m_flag = 0;
    m_dma = hit && m_ctl[7];
    if (wr_en && wr_addr == 1 && !m_ctl[5]) m_act = int'(wr_data);
    else if (upd_evt) m_act = m_pre;
    if (wr_en && wr_addr == 1) m_pre = int'(wr_data);
    if (wr_en && wr_addr == 0) m_ctl = int'(wr_data) & 8'hff;
  endtask

  function automatic int exp_rd();
    case (rd_addr)
      2'd0: return m_ctl;
      2'd1: return m_act;
      2'd2: return int'(m_flag);
      default: return m_pre;
    endcase
  endfunction

  task automatic compare_all();
    chk("R4 ref_lvl", int'(ref_lvl), int'(m_ref));
    chk("R7 ch_out", int'(ch_out), int'(m_ctl[4] && (m_ref ^ m_ctl[3])));
    chk("R3 irq", int'(irq), int'(m_flag && m_ctl[6]));
    chk("R3 dma_req", int'(dma_req), int'(m_dma));
    chk("R11 rd_data", int'(rd_data), exp_rd());
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    wr_en = 0; upd_evt = 0;
    if (cnt_run) cnt_val = (cnt_val == 9) ? '0 : cnt_val + 1'b1;
    rd_addr = rd_addr + 2'd1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = CW'(d);
    step();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(2.5 * 2 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk("R1 ref_lvl", int'(ref_lvl), 0);
    chk("R1 ch_out", int'(ch_out), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1;
    // R8: immediate compare write
    wr(1, 5);
    rd_addr = 1; @(negedge clk); chk("R8 active after direct write", int'(rd_data), 5);
    // R2: stopped counter never hits
    cnt_val = 5; wr(0, 8'h51); run(6);
    rd_addr = 2; @(negedge clk); chk("R2 no flag while stopped", int'(rd_data), 0);
    // R4: set high, with irq and dma enabled, counter running
    cnt_run = 1; cnt_val = 0;
    wr(0, 8'hD1); run(12);
    // R10: clear flag
    cnt_val = 0; cnt_run = 0;
    wr(2, 1);
    rd_addr = 2; @(negedge clk); chk("R10 flag cleared", int'(rd_data), 0);
    // R10: hit and clear together, hit wins
    cnt_val = 5; cnt_run = 1; wr(2, 1);
    cnt_run = 0; rd_addr = 2; @(negedge clk); chk("R10 hit beats clear", int'(rd_data), 1);
    // R4: set low and toggle with inverted polarity
    cnt_run = 1; cnt_val = 0;
    wr(0, 8'hDA); run(12);
    wr(0, 8'hDB); run(25);
    // R5: hold modes across hits
    wr(0, 8'hD0); run(12);
    wr(0, 8'hD7); run(12);
    // R6: forced levels ignore the comparison
    wr(0, 8'hD5); run(12);
    chk("R6 forced high", int'(ref_lvl), 1);
    wr(0, 8'hDC); run(12);
    chk("R6 forced low", int'(ref_lvl), 0);
    // R7: output enable off gates the pin
    wr(0, 8'h0D); run(4);
    chk("R7 disabled output", int'(ch_out), 0);
    // R9: preload path
    wr(0, 8'h31); wr(1, 7);
    rd_addr = 1; @(negedge clk); chk("R9 active unchanged by preload write", int'(rd_data), 5);
    run(10);
    upd_evt = 1; step();
    rd_addr = 1; @(negedge clk); chk("R9 active after update", int'(rd_data), 7);
    run(12);
    wr(1, 2); upd_evt = 1; wr(1, 3); run(12);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule